// File: doc/BRIEF.md
# Flash Erase Region Splitter

This block accepts one request to erase a byte range of a flash device, given as a start offset and a length. It walks that range from low to high addresses and breaks it into a sequence of individual erase commands. Each command is either a small (4 KiB) or a large (64 KiB) erase. At every step the block uses the large erase whenever the current position allows it.

Commands go to a downstream flash cycle engine one at a time. The block raises a one-cycle start strobe together with the erase kind and the address. It then waits for that engine to report completion or failure before it considers the next step.

The request is checked before any command goes out. A range whose start or length is not a whole number of small sectors is refused. A failure reported by the engine ends the walk at once, and the rest of the range is left untouched. While it works, the block shows the offset it has reached and how many commands it has sent, so the exact command order can be observed.

Top module: `erase_splitter`

## Requirements
- R1: If the start offset or the length has any of bits [11:0] set, the block answers with status 1 (argument error) and raises no cmd_start for that request.
- R2: A request with offset aligned and length zero is answered with status 0 (success), and no cmd_start is raised for it.
- R3: Each command uses cmd_kind 1 (64 KiB erase) exactly when its address has bits [15:0] clear and at least 65536 bytes of the range remain. Otherwise it uses cmd_kind 0 (4 KiB erase).
- R4: The first command address equals the request offset. Each later command address is the previous address plus the previous command's size. The request ends with status 0 once the sizes sum to the length.
- R5: cmd_start is high for exactly one cycle per command. No further cmd_start appears until cmd_done or cmd_error has been seen for the outstanding command.
- R6: When cmd_error is seen, the block answers with status 2 (hardware error) and issues no further command for that request. cmd_error takes precedence when cmd_done is asserted in the same cycle.
- R7: req_ready is high only while the block is idle. rsp_valid is a one-cycle pulse carrying rsp_status, encoded 0 = success, 1 = argument error, 2 = hardware error.
- R8: busy is high from the cycle after a request is accepted through the response cycle. issued_count restarts at acceptance and equals the ordinal (counting from 1) of the command during its cmd_start cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Erase request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_offset | input | 32 | Byte offset where the range starts |
| req_length | input | 32 | Byte length of the range |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_status | output | 2 | 0 success, 1 argument error, 2 hardware error |
| cmd_start | output | 1 | One-cycle strobe launching an erase command |
| cmd_kind | output | 1 | 0 = 4 KiB erase, 1 = 64 KiB erase |
| cmd_addr | output | 32 | Byte address of the erase command |
| cmd_done | input | 1 | Downstream reports the command finished |
| cmd_error | input | 1 | Downstream reports the command failed |
| busy | output | 1 | A request is in progress |
| cur_offset | output | 32 | Offset the walk has reached |
| issued_count | output | 16 | Commands issued for the current request |

## Verification
The bench targets ranges that start off a 64 KiB boundary and cross one. A design that chose the size from the remaining length alone would emit a large erase at an unaligned address there. Ranges that are 64 KiB aligned but shorter than 64 KiB catch the opposite mistake of trusting alignment alone. Separate requests misalign only the offset or only the length, which exposes a check that tests just one of them. Failures are injected on the first and on a middle command, one of them with done and error raised together, which exposes a walk that continues, or reports success, after an error.

// File: rtl/erase_split_pkg.sv
package erase_split_pkg;

  typedef enum logic [1:0] {
    ST_OK  = 2'd0,
    ST_ARG = 2'd1,
    ST_HW  = 2'd2
  } esp_status_e;

  typedef enum logic {
    EK_SMALL = 1'b0,
    EK_LARGE = 1'b1
  } esp_kind_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2,
    S_RESP  = 2'd3
  } esp_state_e;

endpackage

// File: rtl/esp_align_check.sv
module esp_align_check #(
  parameter int AW         = 32,
  parameter int SMALL_LOG2 = 12
) (
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] length,
  output logic          aligned,
  output logic          empty
);
  logic off_ok;
  logic len_ok;

  assign off_ok  = (offset[SMALL_LOG2-1:0] == '0);
  assign len_ok  = (length[SMALL_LOG2-1:0] == '0);
  assign aligned = off_ok && len_ok;
  assign empty   = (length == '0);
endmodule

// File: rtl/esp_size_pick.sv
module esp_size_pick
  import erase_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16
) (
  input  logic [AW-1:0] cur_off,
  input  logic [AW-1:0] cur_rem,
  output esp_kind_e     kind,
  output logic [AW-1:0] step
);
  localparam logic [AW-1:0] ONE         = {{(AW-1){1'b0}}, 1'b1};
  localparam logic [AW-1:0] SMALL_BYTES = ONE << SMALL_LOG2;
  localparam logic [AW-1:0] LARGE_BYTES = ONE << LARGE_LOG2;

  logic on_large_boundary;
  logic large_fits;

  assign on_large_boundary = (cur_off[LARGE_LOG2-1:0] == '0);
  assign large_fits        = (cur_rem >= LARGE_BYTES);

  always_comb begin
    if (on_large_boundary && large_fits) begin
      kind = EK_LARGE;
      step = LARGE_BYTES;
    end else begin
      kind = EK_SMALL;
      step = SMALL_BYTES;
    end
  end
endmodule

// File: rtl/esp_ctrl.sv
module esp_ctrl
  import erase_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CNT_W      = 16,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_offset,
  input  logic [AW-1:0]    req_length,
  input  logic             chk_aligned,
  input  logic             chk_empty,
  input  esp_kind_e        pick_kind,
  input  logic [AW-1:0]    pick_step,
  input  logic             cmd_done,
  input  logic             cmd_error,
  output logic             req_ready,
  output logic             rsp_valid,
  output esp_status_e      rsp_status,
  output logic             cmd_start,
  output esp_kind_e        cmd_kind,
  output logic [AW-1:0]    cmd_addr,
  output logic             busy,
  output logic [AW-1:0]    walk_off,
  output logic [AW-1:0]    walk_rem,
  output logic [CNT_W-1:0] issued_count
);
  localparam logic [AW-1:0] LARGE_BYTES = {{(AW-1){1'b0}}, 1'b1} << LARGE_LOG2;

  esp_state_e       state_q,  state_d;
  logic [AW-1:0]    off_q,    off_d;
  logic [AW-1:0]    rem_q,    rem_d;
  logic [CNT_W-1:0] cnt_q,    cnt_d;
  esp_status_e      status_q, status_d;
  logic             accept;
  logic             last_step;

  assign accept    = req_valid && (state_q == S_IDLE);
  assign last_step = (rem_q == pick_step);

  always_comb begin
    state_d  = state_q;
    off_d    = off_q;
    rem_d    = rem_q;
    cnt_d    = cnt_q;
    status_d = status_q;
    unique case (state_q)
      S_IDLE: begin
        if (accept) begin
          off_d = req_offset;
          rem_d = req_length;
          cnt_d = '0;
          if (!chk_aligned) begin
            status_d = ST_ARG;
            state_d  = S_RESP;
          end else if (chk_empty) begin
            status_d = ST_OK;
            state_d  = S_RESP;
          end else begin
            cnt_d   = {{(CNT_W-1){1'b0}}, 1'b1};
            state_d = S_ISSUE;
          end
        end
      end
      S_ISSUE: state_d = S_WAIT;
      S_WAIT: begin
        if (cmd_error) begin
          status_d = ST_HW;
          state_d  = S_RESP;
        end else if (cmd_done) begin
          off_d = off_q + pick_step;
          rem_d = rem_q - pick_step;
          if (last_step) begin
            status_d = ST_OK;
            state_d  = S_RESP;
          end else begin
            cnt_d   = cnt_q + 1'b1;
            state_d = S_ISSUE;
          end
        end
      end
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      off_q    <= '0;
      rem_q    <= '0;
      cnt_q    <= '0;
      status_q <= ST_OK;
    end else begin
      state_q  <= state_d;
      off_q    <= off_d;
      rem_q    <= rem_d;
      cnt_q    <= cnt_d;
      status_q <= status_d;
    end
  end

  assign req_ready    = (state_q == S_IDLE);
  assign rsp_valid    = (state_q == S_RESP);
  assign rsp_status   = status_q;
  assign cmd_start    = (state_q == S_ISSUE);
  assign cmd_kind     = pick_kind;
  assign cmd_addr     = off_q;
  assign busy         = (state_q != S_IDLE);
  assign walk_off     = off_q;
  assign walk_rem     = rem_q;
  assign issued_count = cnt_q;

  // R1: a misaligned request goes straight to an argument-error response
  p_arg_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !chk_aligned) |=> (rsp_valid && rsp_status == ST_ARG && !cmd_start));

  // R2: an empty aligned request answers success without a command
  p_empty_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && chk_aligned && chk_empty) |=> (rsp_valid && rsp_status == ST_OK && !cmd_start));

  // R3: a large erase only at a large boundary with a full large block left
  p_large_fit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_kind == EK_LARGE) |->
      (cmd_addr[LARGE_LOG2-1:0] == '0 && rem_q >= LARGE_BYTES));

  // R1: every command lands on a small-sector boundary
  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> (cmd_addr[SMALL_LOG2-1:0] == '0));

  // R4: a completed command advances the walk by its size
  p_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && cmd_done && !cmd_error) |=>
      (off_q == $past(off_q) + $past(pick_step)));

  // R5: the start strobe lasts one cycle
  p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);

  // R6: an error ends the walk with a hardware-error response
  p_err_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && cmd_error) |=> (rsp_valid && rsp_status == ST_HW && !cmd_start));

  // R7: response is a single-cycle pulse followed by idle
  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: rtl/erase_splitter.sv
module erase_splitter
  import erase_split_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CNT_W      = 16,
  parameter int SMALL_LOG2 = 12,
  parameter int LARGE_LOG2 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_offset,
  input  logic [AW-1:0]    req_length,
  output logic             rsp_valid,
  output logic [1:0]       rsp_status,
  output logic             cmd_start,
  output logic             cmd_kind,
  output logic [AW-1:0]    cmd_addr,
  input  logic             cmd_done,
  input  logic             cmd_error,
  output logic             busy,
  output logic [AW-1:0]    cur_offset,
  output logic [CNT_W-1:0] issued_count
);
  logic          chk_aligned;
  logic          chk_empty;
  esp_kind_e     pick_kind;
  logic [AW-1:0] pick_step;
  logic [AW-1:0] walk_off;
  logic [AW-1:0] walk_rem;
  esp_status_e   status_w;
  esp_kind_e     kind_w;

  esp_align_check #(.AW(AW), .SMALL_LOG2(SMALL_LOG2)) u_check (
    .offset  (req_offset),
    .length  (req_length),
    .aligned (chk_aligned),
    .empty   (chk_empty)
  );

  esp_size_pick #(.AW(AW), .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)) u_pick (
    .cur_off (walk_off),
    .cur_rem (walk_rem),
    .kind    (pick_kind),
    .step    (pick_step)
  );

  esp_ctrl #(.AW(AW), .CNT_W(CNT_W), .SMALL_LOG2(SMALL_LOG2), .LARGE_LOG2(LARGE_LOG2)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_offset   (req_offset),
    .req_length   (req_length),
    .chk_aligned  (chk_aligned),
    .chk_empty    (chk_empty),
    .pick_kind    (pick_kind),
    .pick_step    (pick_step),
    .cmd_done     (cmd_done),
    .cmd_error    (cmd_error),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_status   (status_w),
    .cmd_start    (cmd_start),
    .cmd_kind     (kind_w),
    .cmd_addr     (cmd_addr),
    .busy         (busy),
    .walk_off     (walk_off),
    .walk_rem     (walk_rem),
    .issued_count (issued_count)
  );

  assign rsp_status = status_w;
  assign cmd_kind   = kind_w;
  assign cur_offset = walk_off;
endmodule

// File: tb/tb_erase_splitter.sv
module tb_erase_splitter;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_offset;
  logic [31:0] req_length;
  logic        rsp_valid;
  logic [1:0]  rsp_status;
  logic        cmd_start;
  logic        cmd_kind;
  logic [31:0] cmd_addr;
  logic        cmd_done;
  logic        cmd_error;
  logic        busy;
  logic [31:0] cur_offset;
  logic [15:0] issued_count;

  erase_splitter dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_offset(req_offset), .req_length(req_length), .rsp_valid(rsp_valid),
    .rsp_status(rsp_status), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_done(cmd_done), .cmd_error(cmd_error),
    .busy(busy), .cur_offset(cur_offset), .issued_count(issued_count)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [31:0] exp_addr_q[$];
  logic        exp_kind_q[$];
  int          exp_stat_q[$];
  int          exp_cnt_q[$];

  int err_idx = -1;
  bit err_both = 0;
  int seen_idx = 0;
  int cur_idx = 0;
  int wait_ctr = 0;
  bit outstanding = 0;
  bit rsp_seen = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // Scoreboard monitor and downstream responder
  initial begin
    cmd_done = 0;
    cmd_error = 0;
    forever begin
      @(negedge clk);
      cmd_done = 0;
      cmd_error = 0;
      if (wait_ctr > 0) begin
        wait_ctr--;
        if (wait_ctr == 0) begin
          if (cur_idx == err_idx) begin
            cmd_error = 1;
            cmd_done = err_both;
          end else begin
            cmd_done = 1;
          end
          outstanding = 0;
        end
      end
      if (cmd_start) begin
        check(!outstanding, "R5", "start while outstanding", 1, 0);
        check(!req_ready && busy, "R7", "ready/busy during command",
              {req_ready, busy}, 2'b01);
        check(issued_count == 16'(seen_idx + 1), "R8", "issued_count",
              issued_count, seen_idx + 1);
        if (exp_addr_q.size() == 0) begin
          check(0, "R1", "unexpected command addr", cmd_addr, 0);
        end else begin
          logic [31:0] ea;
          logic ek;
          ea = exp_addr_q.pop_front();
          ek = exp_kind_q.pop_front();
          check(cmd_addr == ea, "R4", "command address", cmd_addr, ea);
          check(cmd_kind == ek, "R3", "command kind", cmd_kind, ek);
        end
        outstanding = 1;
        cur_idx = seen_idx;
        seen_idx++;
        wait_ctr = 2;
      end
      if (rsp_valid) begin
        if (exp_stat_q.size() == 0) begin
          check(0, "R7", "unexpected response", rsp_status, 0);
        end else begin
          int es;
          int ec;
          es = exp_stat_q.pop_front();
          ec = exp_cnt_q.pop_front();
          check(rsp_status == 2'(es), "R7", "response status", rsp_status, es);
          check(issued_count == 16'(ec), "R8", "count at response", issued_count, ec);
          check(busy, "R8", "busy at response", busy, 1);
        end
        rsp_seen = 1;
      end
    end
  end

  // Driver: builds the expected command list from the requirements
  task automatic run_req(input logic [31:0] off, input logic [31:0] len,
                         input int fail_at, input bit both, input string tag);
    logic [31:0] o;
    logic [31:0] r;
    int n;
    int stat;
    o = off;
    r = len;
    n = 0;
    stat = 0;
    if (off[11:0] != 0 || len[11:0] != 0) begin
      stat = 1;
    end else begin
      while (r != 0) begin
        logic big;
        logic [31:0] sz;
        big = (o[15:0] == 0) && (r >= 32'h10000);
        sz = big ? 32'h10000 : 32'h1000;
        exp_addr_q.push_back(o);
        exp_kind_q.push_back(big);
        n++;
        if (n - 1 == fail_at) begin
          stat = 2;
          break;
        end
        o = o + sz;
        r = r - sz;
      end
    end
    exp_stat_q.push_back(stat);
    exp_cnt_q.push_back(n);
    err_idx = fail_at;
    err_both = both;
    seen_idx = 0;
    rsp_seen = 0;
    @(negedge clk);
    req_offset = off;
    req_length = len;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    check(busy, "R8", {tag, " busy after accept"}, busy, 1);
    while (!rsp_seen) @(negedge clk);
    check(exp_addr_q.size() == 0, (stat == 2) ? "R6" : "R4",
          {tag, " commands left unissued"}, exp_addr_q.size(), 0);
    exp_addr_q.delete();
    exp_kind_q.delete();
    @(negedge clk);
    check(req_ready && !busy, "R7", {tag, " idle after response"},
          {req_ready, busy}, 2'b10);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0;
    req_valid = 0;
    req_offset = 0;
    req_length = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && !busy && !cmd_start && !rsp_valid && issued_count == 0,
          "R7", "reset state", {req_ready, busy, cmd_start, rsp_valid}, 4'b1000);

    run_req(32'h0000_0000, 32'h0002_0000, -1, 0, "two large");
    run_req(32'h0000_1000, 32'h0001_1000, -1, 0, "cross boundary");
    run_req(32'h0003_0000, 32'h0000_8000, -1, 0, "aligned short");
    run_req(32'h0004_F000, 32'h0002_2000, -1, 0, "mixed");
    run_req(32'h0000_0800, 32'h0000_1000, -1, 0, "R1 bad offset");
    run_req(32'h0001_0000, 32'h0001_0001, -1, 0, "R1 bad length");
    run_req(32'h0005_0000, 32'h0000_0000, -1, 0, "R2 empty");
    run_req(32'h0000_0000, 32'h0003_0000, 1, 0, "R6 middle error");
    run_req(32'h0002_0000, 32'h0000_3000, 0, 1, "R6 first error both");
    run_req(32'hFFFF_0000, 32'h0001_0000, -1, 0, "top block");
    run_req(32'h0000_F000, 32'h0001_1000, -1, 0, "after error recovery");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule